// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is the target side of a byte-wide serial memory sitting on a two-wire bus (one clock line, one open-drain data line). A system clock much faster than the bus clock oversamples both lines, finds the framing conditions, and steps a small state machine through the address byte, the word-address byte and the data bytes. It then reads or writes an internal array of 2048 bytes.

The address byte carries a fixed leading one, three chip-select bits and three high address bits. The chip-select bits are compared with three strap pins, and the middle strap is matched in inverted form. Eight targets with different straps can share one bus. The three high address bits and the eight-bit word-address byte together form an 11-bit address. A write-lock pin makes the whole array read-only without changing how the bus sees the target. The data line is never driven high: the block only asserts a pull-down enable.

Top module: `tw_mem_target`

## Requirements
- R1: A START (data falling while clock is high) begins a transfer, and a STOP (data rising while clock is high) ends it. Bytes clocked before any START get no acknowledge. After reset the pull-down is off.
- R2: The first byte after START is taken MSB first. It matches only when bit 7 is 1, bit 6 equals strap[2], bit 5 equals the inverse of strap[1] and bit 4 equals strap[0]. A byte that does not match gets no acknowledge, and the rest of the transfer is ignored.
- R3: After a matching address byte, and after every byte received in write mode, the block pulls data low for the whole ninth clock pulse.
- R4: Address-byte bits 3:1 become address bits 10:8. In write mode the next byte becomes address bits 7:0.
- R5: Each further write-mode byte is stored at the current address, and the address then increments, wrapping from 0x7FF to 0x000.
- R6: While the write-lock input is high, data bytes are still acknowledged but memory is left unchanged.
- R7: With address-byte bit 0 set to 1 (read), the block drives bytes MSB first from the current address, incrementing after each byte. It continues while the bus master acknowledges (data low on the ninth pulse).
- R8: A missing master acknowledge (data high on the ninth pulse) makes the block release the line and ignore clocks until the next START.
- R9: A STOP releases the line and returns the block to idle. A repeated START restarts the address-byte phase without an intervening STOP.
- R10: The pull-down enable never switches on while the clock line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pull-down enable for the data line (1 drives low) |
| strap_i | input | 3 | Chip-select strap pins |
| wr_lock_i | input | 1 | High makes the array read-only |

## Verification
The bench acts as a bus master over a wired-AND data line. It sends address bytes with the wrong leading bit, with the middle strap matched uninverted, with no preceding START, and after the straps have been changed. Each case shows whether the select logic and the START gating are what allow an acknowledge. Writes followed by reads through a repeated START, with the address placed mid-array and at the last location, tell correct address assembly, increment and wrap apart from a stuck or unwrapped counter. Repeating a write with the lock pin high, and reading one extra byte after a master not-acknowledge, separate "acknowledged but discarded" from "written" and "released" from "still driving".

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int BYTE_W   = 8;
  localparam int HI_W     = 3;
  localparam int ADDR_W   = HI_W + BYTE_W;
  localparam int CNT_W    = 4;
  localparam int SEL_W    = 3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_ACK,
    S_TX,
    S_TXACK
  } tw_state_e;

  typedef enum logic [1:0] {
    K_DEV,
    K_WADDR,
    K_DATA
  } tw_kind_e;
endpackage

// File: rtl/tw_rst_sync.sv
module tw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = chain[STAGES-1];
endmodule

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_q    = scl_ff[STAGES-1];
  assign sda_q    = sda_ff[STAGES-1];
  assign scl_rise = scl_q & ~scl_d;
  assign scl_fall = ~scl_q & scl_d;
  assign start_p  = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_p   = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/tw_mem.sv
module tw_mem #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/tw_mem_target.sv
module tw_mem_target
  import tw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [SEL_W-1:0] strap_i,
  input  logic             wr_lock_i
);
  localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_W - 1);

  logic rst_n_s;
  logic scl_q, sda_q, scl_rise, scl_fall, start_p, stop_p;

  tw_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  tw_state_e          st_q, st_n;
  tw_kind_e           kind_q, kind_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [BYTE_W-1:0]  sh_q, sh_n;
  logic [ADDR_W-1:0]  addr_q, addr_n;
  logic               rd_q, rd_n;
  logic               mack_q, mack_n;
  logic               oe_q, oe_n;
  logic               mem_we;
  logic [BYTE_W-1:0]  rd_data;
  logic [SEL_W-1:0]   sel_want;
  logic               sel_hit;

  assign sel_want = {strap_i[2], ~strap_i[1], strap_i[0]};
  assign sel_hit  = sh_q[BYTE_W-1] && (sh_q[BYTE_W-2 -: SEL_W] == sel_want);

  tw_mem #(.AW(ADDR_W), .DW(BYTE_W)) u_mem (
    .clk(clk), .we(mem_we), .addr(addr_q), .wdata(sh_q), .rdata(rd_data)
  );

  always_comb begin
    st_n   = st_q;
    kind_n = kind_q;
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    addr_n = addr_q;
    rd_n   = rd_q;
    mack_n = mack_q;
    oe_n   = oe_q;
    mem_we = 1'b0;
    if (stop_p) begin
      st_n = S_IDLE;
      oe_n = 1'b0;
    end else if (start_p) begin
      st_n   = S_RX;
      kind_n = K_DEV;
      cnt_n  = '0;
      oe_n   = 1'b0;
    end else begin
      unique case (st_q)
        S_RX: begin
          if (scl_rise && cnt_q != LAST_RX) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_q};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == LAST_RX) begin
            unique case (kind_q)
              K_DEV: begin
                if (sel_hit) begin
                  addr_n[ADDR_W-1 -: HI_W] = sh_q[HI_W:1];
                  rd_n = sh_q[0];
                  st_n = S_ACK;
                  oe_n = 1'b1;
                end else begin
                  st_n = S_IDLE;
                end
              end
              K_WADDR: begin
                addr_n[BYTE_W-1:0] = sh_q;
                st_n = S_ACK;
                oe_n = 1'b1;
              end
              default: begin
                mem_we = ~wr_lock_i;
                addr_n = addr_q + 1'b1;
                st_n   = S_ACK;
                oe_n   = 1'b1;
              end
            endcase
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (kind_q == K_DEV && rd_q) begin
              st_n = S_TX;
              sh_n = rd_data;
              oe_n = ~rd_data[BYTE_W-1];
            end else begin
              st_n   = S_RX;
              oe_n   = 1'b0;
              kind_n = (kind_q == K_DEV) ? K_WADDR : K_DATA;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (cnt_q == LAST_TX) begin
              st_n   = S_TXACK;
              oe_n   = 1'b0;
              addr_n = addr_q + 1'b1;
            end else begin
              sh_n  = {sh_q[BYTE_W-2:0], 1'b0};
              oe_n  = ~sh_q[BYTE_W-2];
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        S_TXACK: begin
          if (scl_rise) mack_n = ~sda_q;
          if (scl_fall) begin
            if (mack_q) begin
              st_n  = S_TX;
              sh_n  = rd_data;
              oe_n  = ~rd_data[BYTE_W-1];
              cnt_n = '0;
            end else begin
              st_n = S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q   <= S_IDLE;
      kind_q <= K_DEV;
      cnt_q  <= '0;
      sh_q   <= '0;
      addr_q <= '0;
      rd_q   <= 1'b0;
      mack_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      kind_q <= kind_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      addr_q <= addr_n;
      rd_q   <= rd_n;
      mack_q <= mack_n;
      oe_q   <= oe_n;
    end
  end

  assign sda_oe = oe_q;

  // R1: nothing is driven while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st_q == S_IDLE) |-> !sda_oe);

  // R2: a rejected address byte never leads to a pull-down
  a_r2_reject_silent: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st_q == S_RX && kind_q == K_DEV && scl_fall && cnt_q == LAST_RX &&
     !sel_hit && !start_p && !stop_p) |=> (!sda_oe && st_q == S_IDLE));

  // R3: acknowledge phase always holds the line low
  a_r3_ack_drives: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st_q == S_ACK) |-> sda_oe);

  // R9: STOP releases the line on the next cycle
  a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n_s)
    stop_p |=> (!sda_oe && st_q == S_IDLE));

  // R10: the pull-down never turns on during a clock-high interval
  a_r10_no_rise_high: assert property (@(posedge clk) disable iff (!rst_n_s)
    (scl_q && $past(scl_q)) |-> !$rose(sda_oe));
endmodule

// File: tb/tb_tw_mem_target.sv
module tb_tw_mem_target;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       wlock = 1'b0;
  logic       sda_oe;
  wire        sda_line = m_sda & ~sda_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int rise_hi = 0;

  logic [31:0] exp_q[$];
  logic [31:0] act_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  tw_mem_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .strap_i(strap), .wr_lock_i(wlock)
  );

  // R10 monitor: pull-down enable must not turn on while clock stays high
  logic p_scl = 1'b1, p_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl && p_scl && sda_oe && !p_oe) rise_hi++;
    p_scl = scl;
    p_oe  = sda_oe;
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    while (exp_q.size() > 0 && act_q.size() > 0) begin
      logic [31:0] e, a;
      string t;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s actual=%0h expected=%0h", t, a, e);
      end
    end
  end

  task automatic expect_v(input string t, input logic [31:0] v);
    tag_q.push_back(t);
    exp_q.push_back(v);
  endtask

  task automatic observe(input logic [31:0] v);
    act_q.push_back(v);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    tick(8); m_sda = b; tick(8); scl = 1'b1; tick(16); scl = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    tick(8); m_sda = 1'b1; tick(8); scl = 1'b1; tick(8); b = sda_line; tick(8); scl = 1'b0;
  endtask

  task automatic bus_start();
    tick(8); m_sda = 1'b1; tick(8); scl = 1'b1; tick(8); m_sda = 1'b0; tick(8); scl = 1'b0;
  endtask

  task automatic bus_stop();
    tick(8); m_sda = 1'b0; tick(8); scl = 1'b1; tick(8); m_sda = 1'b1; tick(16);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    ack = ~b;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      d[i] = b;
    end
    bit_out(~give_ack);
  endtask

  function automatic logic [7:0] dev(input logic [2:0] hi, input logic rd);
    return {1'b1, strap[2], ~strap[1], strap[0], hi, rd};
  endfunction

  task automatic wr_chk(input string t, input logic [7:0] d, input logic exp_ack);
    logic a;
    wr_byte(d, a);
    expect_v(t, {31'd0, exp_ack});
    observe({31'd0, a});
  endtask

  task automatic rd_chk(input string t, input logic give_ack, input logic [7:0] e);
    logic [7:0] d;
    rd_byte(give_ack, d);
    expect_v(t, {24'd0, e});
    observe({24'd0, d});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(10);
    expect_v("R1 reset pull-down off", 0);
    observe({31'd0, sda_oe});

    // R1: address byte with no START is ignored
    wr_chk("R1 no START no ack", dev(3'd2, 1'b0), 1'b0);
    bus_stop();

    // R2: middle strap not inverted, then leading bit 0
    bus_start();
    wr_chk("R2 uninverted strap rejected", 8'b1_101_000_0, 1'b0);
    bus_stop();
    bus_start();
    wr_chk("R2 leading zero rejected", 8'b0_111_000_0, 1'b0);
    bus_stop();

    // R3/R4/R5: write three bytes at 0x2A5
    bus_start();
    wr_chk("R3 address ack", dev(3'd2, 1'b0), 1'b1);
    wr_chk("R4 word address ack", 8'hA5, 1'b1);
    wr_chk("R5 data ack 0", 8'h11, 1'b1);
    wr_chk("R5 data ack 1", 8'h22, 1'b1);
    wr_chk("R5 data ack 2", 8'h33, 1'b1);
    bus_stop();

    // R7/R8/R9: set address, repeated START, sequential read
    bus_start();
    wr_chk("R4 address ack", dev(3'd2, 1'b0), 1'b1);
    wr_chk("R4 word address ack", 8'hA5, 1'b1);
    bus_start();
    wr_chk("R9 repeated START ack", dev(3'd2, 1'b1), 1'b1);
    rd_chk("R7 read 0x2A5", 1'b1, 8'h11);
    rd_chk("R7 read 0x2A6", 1'b1, 8'h22);
    rd_chk("R8 read 0x2A7 then nack", 1'b0, 8'h33);
    rd_chk("R8 released after nack", 1'b0, 8'hFF);
    bus_stop();

    // R5: wrap from last location to zero
    bus_start();
    wr_chk("R5 address ack", dev(3'd7, 1'b0), 1'b1);
    wr_chk("R5 word address ack", 8'hFF, 1'b1);
    wr_chk("R5 data at 0x7FF", 8'h5A, 1'b1);
    wr_chk("R5 data at 0x000", 8'hC3, 1'b1);
    bus_stop();
    bus_start();
    wr_chk("R5 address ack", dev(3'd7, 1'b0), 1'b1);
    wr_chk("R5 word address ack", 8'hFF, 1'b1);
    bus_start();
    wr_chk("R7 read select ack", dev(3'd7, 1'b1), 1'b1);
    rd_chk("R5 read 0x7FF", 1'b1, 8'h5A);
    rd_chk("R5 read wrapped 0x000", 1'b0, 8'hC3);
    bus_stop();

    // R6: write lock acknowledges but discards
    wlock = 1'b1;
    bus_start();
    wr_chk("R6 address ack locked", dev(3'd2, 1'b0), 1'b1);
    wr_chk("R6 word address ack locked", 8'hA5, 1'b1);
    wr_chk("R6 data ack locked", 8'h00, 1'b1);
    bus_stop();
    wlock = 1'b0;
    bus_start();
    wr_chk("R6 address ack", dev(3'd2, 1'b0), 1'b1);
    wr_chk("R6 word address ack", 8'hA5, 1'b1);
    bus_start();
    wr_chk("R6 read select ack", dev(3'd2, 1'b1), 1'b1);
    rd_chk("R6 content unchanged", 1'b0, 8'h11);
    bus_stop();

    // R9: STOP mid-write returns to idle
    bus_start();
    wr_chk("R9 address ack", dev(3'd2, 1'b0), 1'b1);
    wr_chk("R9 word address ack", 8'h10, 1'b1);
    bus_stop();
    expect_v("R9 released after STOP", 0);
    observe({31'd0, sda_oe});
    wr_chk("R9 byte after STOP ignored", 8'h77, 1'b0);
    bus_stop();

    // R2: new strap setting changes which address is accepted
    strap = 3'b010;
    bus_start();
    wr_chk("R2 old address rejected", 8'b1_111_000_0, 1'b0);
    bus_stop();
    bus_start();
    wr_chk("R2 new strap accepted", dev(3'd0, 1'b0), 1'b1);
    bus_stop();

    expect_v("R10 no pull-down rise with clock high", 0);
    observe(rise_hi);

    tick(20);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule